// File: doc/BRIEF.md
# Multi-Size Unified Translation Buffer

This block is a small, fully associative cache of address translations. It is shared by instruction fetch and data access. Each of its eight slots holds one mapping, which can be a 1MB section, a 64KB large page, a 4KB small page or a 1KB tiny page. A lookup presents a 32-bit virtual address. One cycle later the block returns whether the address hit, the physical address, the 4-bit domain and the 2-bit access permission that applies to that address. Large and small pages carry four permission fields, one for each quarter of the page.

When a lookup misses, the external page-table walker writes the translation through the refill inputs. The refill goes into a slot chosen by a round-robin pointer. That pointer never selects a slot below the programmable lockdown base, so slots under the base keep their translations. Two maintenance commands can remove translations: flush-all, and flush of the slot whose region contains a given address. When a maintenance command arrives in the same cycle as a refill, the command wins.

Top module: `tlb_unified`

## Requirements
- R1: Size codes on `fill_size` are 0 for a 1MB section, 1 for a 64KB large page, 2 for a 4KB small page and 3 for a 1KB tiny page. A lookup hits a valid slot when the virtual address matches the stored base above bit 20, 16, 12 or 10 respectively. The address bits below that point are ignored.
- R2: On a hit, the physical address takes the stored physical base above the region size. Below the region size it takes the looked-up virtual address bits.
- R3: `fill_ap` holds four 2-bit permission fields, with field k in bits [2k+1:2k]. A large page selects its field with address bits [15:14]. A small page selects its field with bits [11:10]. Sections and tiny pages always return field 0.
- R4: Every lookup is answered in the cycle after `lk_req`. The answer raises `rsp_valid` together with exactly one of `rsp_hit` and `rsp_miss`. A miss returns zero physical address, domain and permission. A lookup sees the slot contents as they were before any update at the same clock edge.
- R5: A refill is written at the clock edge that samples `fill_valid`, so a lookup in the next cycle hits. The refill also invalidates every valid slot whose region overlaps the new region, so no address ever matches more than one slot.
- R6: Refills go to slots in round-robin order, starting at slot 0 after reset and wrapping from slot 7 back to the lockdown base. If the pointer lies below a newly raised base, the next refill goes to the base slot.
- R7: `lock_wr` loads `lock_base`. Slots with an index below the base are never chosen for a refill.
- R8: `inv_all` clears every slot and discards any refill presented in the same cycle.
- R9: `inv_va_req` clears only the slots whose region contains `inv_vbase`. A refill in the same cycle is discarded if its own region contains that address. Otherwise the refill is written and the pointer advances.
- R10: After reset all slots are empty, the lockdown base and the pointer are 0, and all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | Lookup hit |
| rsp_miss | output | 1 | Lookup missed |
| rsp_pa | output | 32 | Translated physical address |
| rsp_dom | output | 4 | Domain of the hitting slot |
| rsp_perm | output | 2 | Access permission for the addressed quarter |
| fill_valid | input | 1 | Refill strobe |
| fill_vbase | input | 22 | Virtual address bits [31:10] of the refill |
| fill_pbase | input | 22 | Physical address bits [31:10] of the refill |
| fill_size | input | 2 | Region size code |
| fill_dom | input | 4 | Domain of the refill |
| fill_ap | input | 8 | Four permission fields |
| inv_all | input | 1 | Flush every slot |
| inv_va_req | input | 1 | Flush the slot containing `inv_vbase` |
| inv_vbase | input | 22 | Virtual address bits [31:10] for the flush |
| lock_wr | input | 1 | Load the lockdown base |
| lock_base | input | 3 | New lockdown base |

## Verification
The hardest case to reach from the ports is a refill that meets a flush-by-address in the same cycle, because the outcome depends on whether the flush address falls inside the new region. Regions of several sizes that overlap also create scrubbing conflicts that are hard to provoke. The stimulus reaches both cases by drawing addresses from a narrow pool, so that sections, large, small and tiny pages keep landing on top of one another. Directed sequences add a few fixed cases: a raised lockdown base after the pointer has wrapped, a flush whose address lies inside a concurrent refill, and a flush whose address lies outside it. Every response is compared with a reference model in the bench.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W     = 32;
  localparam int PG_LSB   = 10;
  localparam int TAG_W    = VA_W - PG_LSB;
  localparam int DOM_W    = 4;
  localparam int PERM_W   = 2;
  localparam int NQ       = 4;
  localparam int AP_W     = PERM_W * NQ;
  localparam int SZ_W     = 2;

  localparam logic [SZ_W-1:0] SZ_SECT  = 2'd0;
  localparam logic [SZ_W-1:0] SZ_LARGE = 2'd1;
  localparam logic [SZ_W-1:0] SZ_SMALL = 2'd2;
  localparam logic [SZ_W-1:0] SZ_TINY  = 2'd3;

  localparam int SECT_LG  = 20;
  localparam int LARGE_LG = 16;
  localparam int SMALL_LG = 12;
  localparam int TINY_LG  = 10;

  typedef struct packed {
    logic              valid;
    logic [SZ_W-1:0]   size;
    logic [TAG_W-1:0]  vtag;
    logic [TAG_W-1:0]  ptag;
    logic [DOM_W-1:0]  dom;
    logic [AP_W-1:0]   ap;
  } tlb_ent_t;

  // Tag bits that take part in the compare for a region size.
  function automatic logic [TAG_W-1:0] tag_mask(input logic [SZ_W-1:0] sz);
    logic [TAG_W-1:0] ones;
    ones = '1;
    case (sz)
      SZ_SECT:  tag_mask = ones << (SECT_LG  - PG_LSB);
      SZ_LARGE: tag_mask = ones << (LARGE_LG - PG_LSB);
      SZ_SMALL: tag_mask = ones << (SMALL_LG - PG_LSB);
      default:  tag_mask = ones << (TINY_LG  - PG_LSB);
    endcase
  endfunction

  // Permission field for the addressed quarter.
  function automatic logic [PERM_W-1:0] ap_pick(input logic [AP_W-1:0] ap,
                                                input logic [SZ_W-1:0] sz,
                                                input logic [1:0]      q_large,
                                                input logic [1:0]      q_small);
    logic [1:0] q;
    case (sz)
      SZ_LARGE: q = q_large;
      SZ_SMALL: q = q_small;
      default:  q = 2'd0;
    endcase
    ap_pick = ap[q*PERM_W +: PERM_W];
  endfunction
endpackage

// File: rtl/tlb_entry.sv
module tlb_entry
  import tlb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  tlb_ent_t         wr_ent,
  input  logic             clr,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic [TAG_W-1:0] inv_tag,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [SZ_W-1:0]  fill_size,
  output tlb_ent_t         ent,
  output logic             lk_hit,
  output logic             inv_hit,
  output logic             ovl_hit
);
  tlb_ent_t         ent_q;
  tlb_ent_t         ent_d;
  logic [TAG_W-1:0] own_mask;
  logic [TAG_W-1:0] pair_mask;

  always_comb begin
    ent_d = ent_q;
    if (wr_en) begin
      ent_d = wr_ent;
    end else if (clr) begin
      ent_d.valid = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= '0;
    end else if (wr_en || clr) begin
      ent_q <= ent_d;
    end
  end

  always_comb begin
    own_mask  = tag_mask(ent_q.size);
    pair_mask = own_mask & tag_mask(fill_size);
    lk_hit    = ent_q.valid && (((lk_tag   ^ ent_q.vtag) & own_mask)  == '0);
    inv_hit   = ent_q.valid && (((inv_tag  ^ ent_q.vtag) & own_mask)  == '0);
    ovl_hit   = ent_q.valid && (((fill_tag ^ ent_q.vtag) & pair_mask) == '0);
  end

  assign ent = ent_q;

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ent_q.valid && ent_q.vtag == $past(wr_ent.vtag)
               && ent_q.size == $past(wr_ent.size)))
    else $error("refill did not land in slot"); // R5

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !wr_en) |=> !ent_q.valid)
    else $error("cleared slot still valid"); // R9
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter  int N_ENT = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             lock_wr,
  input  logic [IDX_W-1:0] lock_in,
  output logic [IDX_W-1:0] victim,
  output logic [IDX_W-1:0] base
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENT - 1);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_d;
  logic [IDX_W-1:0] base_q;
  logic [IDX_W-1:0] base_d;

  always_comb begin
    victim = (ptr_q < base_q) ? base_q : ptr_q;
  end

  always_comb begin
    ptr_d  = ptr_q;
    base_d = base_q;
    if (adv) begin
      ptr_d = (victim == LAST) ? base_q : victim + 1'b1;
    end
    if (lock_wr) begin
      base_d = lock_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (adv) begin
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (lock_wr) begin
      base_q <= base_d;
    end
  end

  assign base = base_q;

  AST_RR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !lock_wr && victim != LAST) |=> (victim == $past(victim) + 1'b1))
    else $error("round-robin pointer skipped"); // R6

  AST_RR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !lock_wr && victim == LAST) |=> (victim == base))
    else $error("round-robin wrap missed base"); // R6
endmodule

// File: rtl/tlb_unified.sv
module tlb_unified
  import tlb_pkg::*;
#(
  parameter  int N_ENT = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lk_req,
  input  logic [VA_W-1:0]       lk_va,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  output logic                  rsp_miss,
  output logic [VA_W-1:0]       rsp_pa,
  output logic [DOM_W-1:0]      rsp_dom,
  output logic [PERM_W-1:0]     rsp_perm,
  input  logic                  fill_valid,
  input  logic [VA_W-1:PG_LSB]  fill_vbase,
  input  logic [VA_W-1:PG_LSB]  fill_pbase,
  input  logic [SZ_W-1:0]       fill_size,
  input  logic [DOM_W-1:0]      fill_dom,
  input  logic [AP_W-1:0]       fill_ap,
  input  logic                  inv_all,
  input  logic                  inv_va_req,
  input  logic [VA_W-1:PG_LSB]  inv_vbase,
  input  logic                  lock_wr,
  input  logic [IDX_W-1:0]      lock_base
);
  // reset: asserted at once, released on a clock edge
  logic rst_meta;
  logic rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic [TAG_W-1:0] lk_tag;
  logic [TAG_W-1:0] fill_mask;
  tlb_ent_t         new_ent;
  logic             fill_in_inv;
  logic             fill_acc;
  logic [IDX_W-1:0] victim;
  logic [IDX_W-1:0] base_q;

  tlb_ent_t         ents     [N_ENT];
  logic [N_ENT-1:0] lk_hit_v;
  logic [N_ENT-1:0] inv_hit_v;
  logic [N_ENT-1:0] ovl_hit_v;
  logic [N_ENT-1:0] valid_v;
  logic [N_ENT-1:0] wr_v;
  logic [N_ENT-1:0] clr_v;

  assign lk_tag = lk_va[VA_W-1:PG_LSB];

  // refill admission against concurrent maintenance
  always_comb begin
    fill_mask   = tag_mask(fill_size);
    fill_in_inv = ((fill_vbase ^ inv_vbase) & fill_mask) == '0;
    fill_acc    = fill_valid && !inv_all && !(inv_va_req && fill_in_inv);
    new_ent       = '0;
    new_ent.valid = 1'b1;
    new_ent.size  = fill_size;
    new_ent.vtag  = fill_vbase & fill_mask;
    new_ent.ptag  = fill_pbase & fill_mask;
    new_ent.dom   = fill_dom;
    new_ent.ap    = fill_ap;
  end

  tlb_victim #(.N_ENT(N_ENT)) u_victim (
    .clk     (clk),
    .rst_n   (rst_s),
    .adv     (fill_acc),
    .lock_wr (lock_wr),
    .lock_in (lock_base),
    .victim  (victim),
    .base    (base_q)
  );

  for (genvar gi = 0; gi < N_ENT; gi++) begin : g_slot
    assign wr_v[gi]  = fill_acc && (victim == IDX_W'(gi));
    assign clr_v[gi] = inv_all || (inv_va_req && inv_hit_v[gi])
                       || (fill_acc && ovl_hit_v[gi]);
    assign valid_v[gi] = ents[gi].valid;

    tlb_entry u_entry (
      .clk       (clk),
      .rst_n     (rst_s),
      .wr_en     (wr_v[gi]),
      .wr_ent    (new_ent),
      .clr       (clr_v[gi]),
      .lk_tag    (lk_tag),
      .inv_tag   (inv_vbase),
      .fill_tag  (fill_vbase),
      .fill_size (fill_size),
      .ent       (ents[gi]),
      .lk_hit    (lk_hit_v[gi]),
      .inv_hit   (inv_hit_v[gi]),
      .ovl_hit   (ovl_hit_v[gi])
    );
  end

  // hit mux: at most one slot matches, so an OR tree is enough
  logic [TAG_W-1:0]  sel_ptag;
  logic [SZ_W-1:0]   sel_size;
  logic [DOM_W-1:0]  sel_dom;
  logic [AP_W-1:0]   sel_ap;
  logic              any_hit;
  logic [TAG_W-1:0]  sel_mask;
  logic              hit_d;
  logic              miss_d;
  logic [VA_W-1:0]   pa_d;
  logic [DOM_W-1:0]  dom_d;
  logic [PERM_W-1:0] perm_d;

  always_comb begin
    sel_ptag = '0;
    sel_size = '0;
    sel_dom  = '0;
    sel_ap   = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (lk_hit_v[i]) begin
        sel_ptag = sel_ptag | ents[i].ptag;
        sel_size = sel_size | ents[i].size;
        sel_dom  = sel_dom  | ents[i].dom;
        sel_ap   = sel_ap   | ents[i].ap;
      end
    end
    any_hit  = |lk_hit_v;
    sel_mask = tag_mask(sel_size);
  end

  always_comb begin
    hit_d  = lk_req && any_hit;
    miss_d = lk_req && !any_hit;
    pa_d   = '0;
    dom_d  = '0;
    perm_d = '0;
    if (hit_d) begin
      pa_d   = {(sel_ptag & sel_mask) | (lk_tag & ~sel_mask), lk_va[PG_LSB-1:0]};
      dom_d  = sel_dom;
      perm_d = ap_pick(sel_ap, sel_size,
                       lk_va[LARGE_LG-1 -: 2], lk_va[SMALL_LG-1 -: 2]);
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_pa    <= '0;
      rsp_dom   <= '0;
      rsp_perm  <= '0;
    end else begin
      rsp_valid <= lk_req;
      rsp_hit   <= hit_d;
      rsp_miss  <= miss_d;
      rsp_pa    <= pa_d;
      rsp_dom   <= dom_d;
      rsp_perm  <= perm_d;
    end
  end

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(lk_hit_v))
    else $error("lookup matched several slots"); // R5

  AST_LOCKED_SPARED: assert property (@(posedge clk) disable iff (!rst_s)
    fill_acc |-> (victim >= base_q))
    else $error("refill aimed at locked slot"); // R7

  AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rst_s)
    inv_all |=> (valid_v == '0))
    else $error("slot survived flush-all"); // R8

  AST_RSP_EXCL: assert property (@(posedge clk) disable iff (!rst_s)
    rsp_valid |-> (rsp_hit != rsp_miss))
    else $error("response not exactly hit or miss"); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_s)
    !rsp_valid |-> (!rsp_hit && !rsp_miss))
    else $error("hit or miss without request"); // R4

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_s)
    rsp_miss |-> (rsp_pa == '0 && rsp_dom == '0 && rsp_perm == '0))
    else $error("miss carried data"); // R4
endmodule

// File: tb/tlb_unified_tb_top.sv
`timescale 1ns/1ps
module tlb_unified_tb_top;
  localparam int N_ENT = 8;

  logic        clk;
  logic        rst_n;
  logic        lk_req;
  logic [31:0] lk_va;
  logic        rsp_valid, rsp_hit, rsp_miss;
  logic [31:0] rsp_pa;
  logic [3:0]  rsp_dom;
  logic [1:0]  rsp_perm;
  logic        fill_valid;
  logic [31:10] fill_vbase, fill_pbase;
  logic [1:0]  fill_size;
  logic [3:0]  fill_dom;
  logic [7:0]  fill_ap;
  logic        inv_all, inv_va_req;
  logic [31:10] inv_vbase;
  logic        lock_wr;
  logic [2:0]  lock_base;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  tlb_unified dut_i (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_pa(rsp_pa), .rsp_dom(rsp_dom), .rsp_perm(rsp_perm),
    .fill_valid(fill_valid), .fill_vbase(fill_vbase), .fill_pbase(fill_pbase),
    .fill_size(fill_size), .fill_dom(fill_dom), .fill_ap(fill_ap),
    .inv_all(inv_all), .inv_va_req(inv_va_req), .inv_vbase(inv_vbase),
    .lock_wr(lock_wr), .lock_base(lock_base)
  );

  // reference model
  bit          m_v  [N_ENT];
  logic [1:0]  m_sz [N_ENT];
  logic [21:0] m_vt [N_ENT];
  logic [21:0] m_pt [N_ENT];
  logic [3:0]  m_dom[N_ENT];
  logic [7:0]  m_ap [N_ENT];
  int m_base;
  int m_ptr;
  int n_chk;
  int n_fail;
  bit done;

  function automatic logic [21:0] b_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 22'h3FFC00;
      2'd1:    return 22'h3FFFC0;
      2'd2:    return 22'h3FFFFC;
      default: return 22'h3FFFFF;
    endcase
  endfunction

  function automatic bit b_in(input logic [21:0] a, input logic [21:0] vt, input logic [1:0] sz);
    return ((a ^ vt) & b_mask(sz)) == 22'h0;
  endfunction

  function automatic logic [1:0] b_perm(input logic [7:0] ap, input logic [1:0] sz, input logic [31:0] va);
    int q;
    q = (sz == 2'd1) ? int'(va[15:14]) : (sz == 2'd2) ? int'(va[11:10]) : 0;
    return 2'((ap >> (2*q)) & 8'h3);
  endfunction

  task automatic model_update();
    bit acc;
    int vic;
    acc = fill_valid && !inv_all && !(inv_va_req && b_in(inv_vbase, fill_vbase, fill_size));
    vic = (m_ptr < m_base) ? m_base : m_ptr;
    for (int i = 0; i < N_ENT; i++) begin
      if (acc && i == vic) begin
        m_v[i] = 1'b1; m_sz[i] = fill_size;
        m_vt[i] = fill_vbase & b_mask(fill_size);
        m_pt[i] = fill_pbase & b_mask(fill_size);
        m_dom[i] = fill_dom; m_ap[i] = fill_ap;
      end else if (inv_all || (inv_va_req && m_v[i] && b_in(inv_vbase, m_vt[i], m_sz[i]))
                   || (acc && m_v[i] && (((m_vt[i] ^ fill_vbase) & b_mask(m_sz[i]) & b_mask(fill_size)) == 22'h0))) begin
        m_v[i] = 1'b0;
      end
    end
    if (acc) m_ptr = (vic == N_ENT-1) ? m_base : vic + 1;
    if (lock_wr) m_base = int'(lock_base);
  endtask

  task automatic tick(input string tag);
    bit e_val, e_hit;
    logic [31:0] e_pa;
    logic [3:0]  e_dom;
    logic [1:0]  e_perm;
    @(posedge clk);
    #2;
    e_val = lk_req; e_hit = 1'b0; e_pa = '0; e_dom = '0; e_perm = '0;
    if (lk_req) begin
      for (int i = 0; i < N_ENT; i++) begin
        if (m_v[i] && b_in(lk_va[31:10], m_vt[i], m_sz[i])) begin
          e_hit  = 1'b1;
          e_pa   = {(m_pt[i] & b_mask(m_sz[i])) | (lk_va[31:10] & ~b_mask(m_sz[i])), lk_va[9:0]};
          e_dom  = m_dom[i];
          e_perm = b_perm(m_ap[i], m_sz[i], lk_va);
        end
      end
    end
    model_update();
    n_chk++;
    if (rsp_valid !== e_val || rsp_hit !== e_hit || rsp_miss !== (e_val && !e_hit) ||
        rsp_pa !== e_pa || rsp_dom !== e_dom || rsp_perm !== e_perm) begin
      n_fail++;
      $display("FAIL %s: actual v=%0b h=%0b m=%0b pa=%h dom=%h perm=%0d expected v=%0b h=%0b m=%0b pa=%h dom=%h perm=%0d",
               tag, rsp_valid, rsp_hit, rsp_miss, rsp_pa, rsp_dom, rsp_perm,
               e_val, e_hit, e_val && !e_hit, e_pa, e_dom, e_perm);
    end
  endtask

  task automatic want(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    lk_req = 0; lk_va = '0; fill_valid = 0; fill_vbase = '0; fill_pbase = '0;
    fill_size = '0; fill_dom = '0; fill_ap = '0; inv_all = 0; inv_va_req = 0;
    inv_vbase = '0; lock_wr = 0; lock_base = '0;
  endtask

  task automatic set_fill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz,
                          input logic [3:0] dom, input logic [7:0] ap);
    fill_valid = 1; fill_vbase = va[31:10]; fill_pbase = pa[31:10];
    fill_size = sz; fill_dom = dom; fill_ap = ap;
  endtask

  task automatic fill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz,
                      input logic [3:0] dom, input logic [7:0] ap);
    set_fill(va, pa, sz, dom, ap);
    tick("R5 refill");
    idle();
  endtask

  task automatic look(input logic [31:0] va, input string tag);
    lk_req = 1; lk_va = va;
    tick(tag);
    idle();
  endtask

  function automatic logic [31:0] rand_va();
    logic [31:0] v;
    v = $urandom;
    v[31:20] = ($urandom % 2) ? 12'h001 : 12'h002;
    v[19:16] = ($urandom % 2) ? 4'h3 : 4'h0;
    v[15:10] = 6'($urandom % 64) & 6'b110011;
    return v;
  endfunction

  initial begin
    int unsigned seed_set;
    seed_set = $urandom(32'd20240611);
    n_chk = 0; n_fail = 0; done = 0;
    for (int i = 0; i < N_ENT; i++) m_v[i] = 0;
    m_base = 0; m_ptr = 0;
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2;
    want("R10 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    want("R10 reset rsp_pa", rsp_pa, 32'd0);
    @(negedge clk);
    rst_n = 1;
    repeat (3) tick("R10 idle after reset");

    look(32'h1234_5678, "R10 empty after reset");
    // same-cycle refill and lookup: lookup sees old contents
    set_fill(32'h1230_0000, 32'h4560_0000, 2'd0, 4'd5, 8'hE4);
    lk_req = 1; lk_va = 32'h123A_BCDE;
    tick("R4 lookup alongside refill");
    idle();
    look(32'h123A_BCDE, "R2 section translation");
    want("R2 section pa", rsp_pa, 32'h456A_BCDE);
    want("R5 hit after refill", {31'd0, rsp_hit}, 32'd1);
    look(32'h1240_0000, "R1 outside section");
    want("R4 miss flag", {31'd0, rsp_miss}, 32'd1);

    fill(32'h0001_0000, 32'h8002_0000, 2'd1, 4'd3, 8'hE4);
    look(32'h0001_C123, "R3 large quarter 3");
    want("R3 large perm q3", {30'd0, rsp_perm}, 32'd3);
    want("R2 large pa", rsp_pa, 32'h8002_C123);
    look(32'h0001_4000, "R3 large quarter 1");
    want("R3 large perm q1", {30'd0, rsp_perm}, 32'd1);
    look(32'h0002_0000, "R1 outside large");

    fill(32'h0020_0000, 32'h0050_0000, 2'd2, 4'd1, 8'h1B);
    look(32'h0020_0C00, "R3 small quarter 3");
    want("R3 small perm q3", {30'd0, rsp_perm}, 32'd0);
    look(32'h0020_0400, "R3 small quarter 1");
    want("R3 small perm q1", {30'd0, rsp_perm}, 32'd2);

    fill(32'h0030_0400, 32'h0070_0800, 2'd3, 4'd2, 8'h02);
    look(32'h0030_07FF, "R1 tiny inside");
    want("R1 tiny pa", rsp_pa, 32'h0070_0BFF);
    look(32'h0030_0800, "R1 tiny outside");

    // section on top of the small page scrubs it
    fill(32'h0020_0000, 32'h0090_0000, 2'd0, 4'd7, 8'h03);
    look(32'h0020_0400, "R5 overlap scrub");
    want("R5 overlap pa", rsp_pa, 32'h0090_0400);

    // flush by address with an unrelated refill
    inv_va_req = 1; inv_vbase = 22'(32'h1230_0010 >> 10);
    set_fill(32'h0040_0000, 32'h00A0_0000, 2'd2, 4'd4, 8'h00);
    tick("R9 flush plus refill");
    idle();
    look(32'h123A_BCDE, "R9 flushed section");
    look(32'h0040_0000, "R9 refill kept");
    want("R9 refill kept hit", {31'd0, rsp_hit}, 32'd1);
    // flush address inside the refill: refill dropped
    inv_va_req = 1; inv_vbase = 22'(32'h0001_0000 >> 10);
    set_fill(32'h0001_0000, 32'h8002_0000, 2'd1, 4'd3, 8'hE4);
    tick("R9 refill dropped");
    idle();
    look(32'h0001_C123, "R9 dropped refill misses");
    want("R9 dropped miss", {31'd0, rsp_miss}, 32'd1);
    look(32'h0030_07FF, "R9 other slot kept");

    inv_all = 1;
    set_fill(32'h0060_0000, 32'h0060_0000, 2'd0, 4'd0, 8'h00);
    tick("R8 flush-all with refill");
    idle();
    look(32'h0060_0000, "R8 refill discarded");
    look(32'h0030_07FF, "R8 all cleared");
    want("R8 cleared miss", {31'd0, rsp_miss}, 32'd1);

    // round robin: nine tiny pages through eight slots
    for (int k = 0; k < 9; k++) fill(32'h00A0_0000 + k*32'h400, 32'h0100_0000 + k*32'h400, 2'd3, 4'd1, 8'h01);
    look(32'h00A0_0000, "R6 oldest evicted");
    want("R6 oldest evicted miss", {31'd0, rsp_miss}, 32'd1);
    look(32'h00A0_0400, "R6 second kept");

    lock_wr = 1; lock_base = 3'd4;
    tick("R7 lock write");
    idle();
    for (int k = 0; k < 6; k++) fill(32'h00B0_0000 + k*32'h400, 32'h0200_0000 + k*32'h400, 2'd3, 4'd2, 8'h02);
    for (int k = 2; k < 6; k++) begin
      look(32'h00A0_0000 + k*32'h400, "R7 locked slot kept");
      want("R7 locked hit", {31'd0, rsp_hit}, 32'd1);
    end
    lock_wr = 1; lock_base = 3'd6;
    tick("R6 raise base");
    idle();
    fill(32'h00C0_0000, 32'h0300_0000, 2'd3, 4'd3, 8'h03);
    look(32'h00B0_0C00, "R6 base slot replaced");
    look(32'h00B0_0800, "R6 slot below base kept");

    // constrained random
    for (int n = 0; n < 5000; n++) begin
      lk_req = ($urandom % 4) != 0;
      lk_va  = rand_va();
      if (($urandom % 5) == 0) set_fill(rand_va(), $urandom, 2'($urandom % 4), 4'($urandom), 8'($urandom));
      inv_va_req = ($urandom % 25) == 0;
      inv_vbase  = rand_va() >> 10;
      inv_all    = ($urandom % 300) == 0;
      lock_wr    = ($urandom % 200) == 0;
      lock_base  = 3'($urandom % 8);
      tick("R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
      idle();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R4 watchdog: actual still running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule